// File: doc/BRIEF.md
# Counter Capture/Compare Channel

This block is a single capture/compare channel that sits beside a free-running counter core; a counter with three such channels instantiates it three times. It receives the main count and the pre-counter value every clock, and every clock is one count-clock cycle. The channel has three modes. When off, it does nothing. In compare mode it checks a programmable reference against a selected count word and drives its output pin through one of four actions when the words first become equal. In capture mode it watches one of several trigger lines, detects the chosen kind of transition and stores the main count.

The compared word is either the main count or a combined word. The combined word puts the low counter bits above the whole pre-counter. A mask field removes a programmable number of most significant bits from the comparison, so a single reference can match periodically.

Top module: `cc_channel`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `ch_out`, `ch_event` and `cap_value` are all zero.
- R2: In compare mode (`cfg_mode` = 2), `ch_event` is high for one cycle after the first clock on which the masked compare word equals `cmp_value`. It is not raised again while the words stay equal. It fires again only after a cycle of inequality.
- R3: `cfg_base` = 0 compares against `cnt_val`. `cfg_base` = 1 compares against `{cnt_val[16:0], pre_val[14:0]}`, with the counter bits in the upper part.
- R4: `cfg_mask` = m excludes the m most significant bits of the 32-bit compare word from matching.
- R5: With action pulse (`cfg_action` = 0) in compare mode, `ch_out` is high for exactly the cycle in which `ch_event` is high.
- R6: Actions toggle (1), clear (2) and set (3) respectively invert, drive low or drive high `ch_out` on each compare event. Otherwise `ch_out` holds its value.
- R7: The selected trigger line passes through two synchronizing flops before edge detection. In capture mode (`cfg_mode` = 1), a detected edge loads `cap_value` with the `cnt_val` of the detection cycle and raises `ch_event` for that cycle. A trigger change sampled at edge k is captured at edge k+2.
- R8: `cfg_edge` = 1 detects falling edges and `cfg_edge` = 2 detects both edges of the synchronized trigger.
- R9: `cfg_edge` = 3 uses no edge detection: every cycle in which the synchronized trigger is high causes a capture.
- R10: Only the trigger line selected by `cfg_trig_sel` has any effect. Activity on the other lines leaves `ch_event` and `cap_value` unchanged.
- R11: In off mode (`cfg_mode` = 0), neither a compare equality nor a trigger edge raises `ch_event`, and `cap_value` holds its value.
- R12: An all-zero setting of action, base, edge and trigger select gives the default setup: pulse action on the main counter, and rising-edge capture from trigger line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 32 | Main counter value |
| pre_val | input | 15 | Pre-counter value |
| trig_in | input | 4 | Candidate trigger lines |
| cfg_mode | input | 2 | 0 off, 1 capture, 2 compare (3 acts as off) |
| cfg_action | input | 2 | 0 pulse, 1 toggle, 2 clear, 3 set |
| cfg_edge | input | 2 | 0 rising, 1 falling, 2 both, 3 level pass-through |
| cfg_base | input | 1 | 0 main counter, 1 combined word |
| cfg_mask | input | 5 | Number of ignored compare MSBs |
| cfg_trig_sel | input | 2 | Trigger line index |
| cmp_value | input | 32 | Compare reference |
| ch_out | output | 1 | Channel output pin |
| cap_value | output | 32 | Captured count |
| ch_event | output | 1 | Match or capture event |

## Verification
The bench builds the channel with its default parameters: a 32-bit count word, a 15-bit pre-counter, four trigger lines and a two-stage synchronizer. The 17/15 split of the combined word and the full 0 to 31 mask range are therefore reachable. A mask of 28 leaves four compared bits, so a rising counter re-matches every 16 counts within a short run. That exposes the fire-once rule and the toggle and pulse sequences. Four trigger lines let the bench drive an unselected line and observe that it has no effect.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    CC_OFF     = 2'd0,
    CC_CAPTURE = 2'd1,
    CC_COMPARE = 2'd2
  } cc_mode_e;

  typedef enum logic [1:0] {
    ACT_PULSE  = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } cc_action_e;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'd0,
    EDGE_FALL  = 2'd1,
    EDGE_BOTH  = 2'd2,
    EDGE_LEVEL = 2'd3
  } cc_edge_e;
endpackage

// File: rtl/cc_trig_detect.sv
module cc_trig_detect #(
  parameter int NUM_TRIG    = 4,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]    trig_sel,
  input  logic [1:0]          edge_sel,
  output logic                detect
);
  import cc_pkg::*;

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   picked, level;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (trig_sel == SEL_W'(i)) picked = trig_in[i];
    end
  end

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], picked};
    end else begin : g_single
      assign sync_d = picked;
    end
  endgenerate

  assign level  = sync_q[LAST];
  assign prev_d = level;

  always_comb begin
    case (cc_edge_e'(edge_sel))
      EDGE_RISE: detect = level & ~prev_q;
      EDGE_FALL: detect = ~level & prev_q;
      EDGE_BOTH: detect = level ^ prev_q;
      default:   detect = level;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/cc_match.sv
module cc_match #(
  parameter int W      = 32,
  parameter int MASK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [W-1:0]      word,
  input  logic [W-1:0]      ref_val,
  input  logic [MASK_W-1:0] mask_msb,
  output logic              first_hit
);
  logic [W-1:0] keep;
  logic         equal, equal_q;

  assign keep      = {W{1'b1}} >> mask_msb;
  assign equal     = ((word ^ ref_val) & keep) == '0;
  assign first_hit = arm & equal & ~equal_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) equal_q <= 1'b0;
    else        equal_q <= equal;
  end
endmodule

// File: rtl/cc_out_ctrl.sv
module cc_out_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [1:0] action,
  output logic       pin
);
  import cc_pkg::*;

  logic pin_d;

  always_comb begin
    pin_d = pin;
    case (cc_action_e'(action))
      ACT_PULSE:  pin_d = fire;
      ACT_TOGGLE: pin_d = pin ^ fire;
      ACT_CLEAR:  if (fire) pin_d = 1'b0;
      default:    if (fire) pin_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= pin_d;
  end
endmodule

// File: rtl/cc_channel.sv
module cc_channel #(
  parameter int CNT_W       = 32,
  parameter int PRE_W       = 15,
  parameter int MASK_W      = 5,
  parameter int NUM_TRIG    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = $clog2(NUM_TRIG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    cnt_val,
  input  logic [PRE_W-1:0]    pre_val,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [1:0]          cfg_mode,
  input  logic [1:0]          cfg_action,
  input  logic [1:0]          cfg_edge,
  input  logic                cfg_base,
  input  logic [MASK_W-1:0]   cfg_mask,
  input  logic [SEL_W-1:0]    cfg_trig_sel,
  input  logic [CNT_W-1:0]    cmp_value,
  output logic                ch_out,
  output logic [CNT_W-1:0]    cap_value,
  output logic                ch_event
);
  import cc_pkg::*;

  localparam int HI_W = CNT_W - PRE_W;

  logic [CNT_W-1:0] comb_word, cmp_word, cap_d;
  logic             is_cmp, is_cap, hit, edge_seen, cap_en, event_d;

  assign is_cmp    = cc_mode_e'(cfg_mode) == CC_COMPARE;
  assign is_cap    = cc_mode_e'(cfg_mode) == CC_CAPTURE;
  assign comb_word = {cnt_val[HI_W-1:0], pre_val};
  assign cmp_word  = cfg_base ? comb_word : cnt_val;

  cc_match #(.W(CNT_W), .MASK_W(MASK_W)) u_match (
    .clk(clk), .rst_n(rst_n), .arm(is_cmp), .word(cmp_word),
    .ref_val(cmp_value), .mask_msb(cfg_mask), .first_hit(hit)
  );

  cc_trig_detect #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_sel(cfg_trig_sel),
    .edge_sel(cfg_edge), .detect(edge_seen)
  );

  cc_out_ctrl u_out (
    .clk(clk), .rst_n(rst_n), .fire(hit), .action(cfg_action), .pin(ch_out)
  );

  assign cap_en  = is_cap & edge_seen;
  assign cap_d   = cap_en ? cnt_val : cap_value;
  assign event_d = (is_cmp & hit) | cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_value <= '0;
      ch_event  <= 1'b0;
    end else begin
      cap_value <= cap_d;
      ch_event  <= event_d;
    end
  end
endmodule

// File: rtl/cc_channel_chk.sv
module cc_channel_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_mode,
  input logic [1:0]       cfg_action,
  input logic             ch_out,
  input logic             ch_event,
  input logic [CNT_W-1:0] cap_value
);
  p_single_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd2 && $past(cfg_mode) == 2'd2 && ch_event) |=> !ch_event);

  p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_mode) == 2'd2 && $past(cfg_action) == 2'd0) |-> (ch_out == ch_event));

  p_set_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_action) == 2'd3 && $past(ch_out)) |-> ch_out);

  p_cap_only_on_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_value) |-> ch_event);

  p_off_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_mode) == 2'd0) |-> !ch_event);
endmodule

bind cc_channel cc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_action(cfg_action),
  .ch_out(ch_out), .ch_event(ch_event), .cap_value(cap_value)
);

// File: tb/sim_cc_channel.sv
`timescale 1ns/1ps
module sim_cc_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cnt_val = '0;
  logic [14:0] pre_val = '0;
  logic [3:0]  trig_in = '0;
  logic [1:0]  cfg_mode = '0, cfg_action = '0, cfg_edge = '0, cfg_trig_sel = '0;
  logic        cfg_base = 1'b0;
  logic [4:0]  cfg_mask = '0;
  logic [31:0] cmp_value = '0;
  logic        ch_out, ch_event;
  logic [31:0] cap_value;

  logic        load_en = 1'b0;
  logic [31:0] load_val = '0;
  logic [31:0] cnt_step = '0;

  int    checks = 0, errors = 0, ev_count = 0, hi_count = 0;
  bit    done = 0;
  string cur_req = "R1";

  logic        m_out = 0, m_ev = 0, m_prev_eq = 0;
  logic [31:0] m_cap = '0;
  bit          hist[$] = '{0, 0, 0};

  always #5 clk = ~clk;

  cc_channel u0 (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .pre_val(pre_val), .trig_in(trig_in),
    .cfg_mode(cfg_mode), .cfg_action(cfg_action), .cfg_edge(cfg_edge), .cfg_base(cfg_base),
    .cfg_mask(cfg_mask), .cfg_trig_sel(cfg_trig_sel), .cmp_value(cmp_value),
    .ch_out(ch_out), .cap_value(cap_value), .ch_event(ch_event)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (load_en) cnt_val = load_val;
    else         cnt_val = cnt_val + cnt_step;
  end

  // behavioural reference, evaluated with the inputs present before the edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = 0; m_ev = 0; m_cap = '0; m_prev_eq = 0;
      hist = '{0, 0, 0};
    end else begin
      logic [31:0] w;
      bit eq, hit, det, lvl, old;
      w  = cfg_base ? {cnt_val[16:0], pre_val} : cnt_val;
      eq = 1;
      for (int i = 0; i < 32; i++)
        if (i < 32 - cfg_mask && w[i] != cmp_value[i]) eq = 0;
      hit = (cfg_mode == 2) && eq && !m_prev_eq;
      m_prev_eq = eq;
      lvl = hist[1];
      old = hist[2];
      case (cfg_edge)
        0: det = lvl && !old;
        1: det = !lvl && old;
        2: det = lvl != old;
        default: det = lvl;
      endcase
      hist.push_front(trig_in[cfg_trig_sel]);
      void'(hist.pop_back());
      m_ev = (cfg_mode == 2) ? hit : (cfg_mode == 1) ? det : 0;
      if (cfg_mode == 1 && det) m_cap = cnt_val;
      case (cfg_action)
        0: m_out = hit;
        1: m_out = m_out ^ hit;
        2: if (hit) m_out = 0;
        default: if (hit) m_out = 1;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, 32'(ch_out), 32'(m_out));
      chk(cur_req, 32'(ch_event), 32'(m_ev));
      chk(cur_req, cap_value, m_cap);
      if (ch_event) ev_count++;
      if (ch_out)   hi_count++;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      load_en = 1'b0;
    end
  endtask

  task automatic load(input logic [31:0] v, input logic [31:0] s);
    load_en = 1'b1; load_val = v; cnt_step = s;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int e0, h0;
    step(3);
    chk("R1", 32'(ch_out), 0); chk("R1", 32'(ch_event), 0); chk("R1", cap_value, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 32'(ch_out), 0); chk("R1", 32'(ch_event), 0); chk("R1", cap_value, 0);

    // R2: single fire, hold while equal, re-fire after inequality
    step(1); cur_req = "R2";
    cfg_mode = 2; cmp_value = 20; load(0, 1);
    e0 = ev_count; step(30);
    chk("R2", ev_count - e0, 1);
    load(20, 0); e0 = ev_count; step(10);
    chk("R2", ev_count - e0, 1);

    // R3: combined word
    cur_req = "R3"; cfg_base = 1; pre_val = 15'h1234;
    cmp_value = (32'd5 << 15) | 32'h1234; load(32'hABC0_0000, 1);
    e0 = ev_count; step(20);
    chk("R3", ev_count - e0, 1);

    // R4/R5: masked match with pulse output
    cur_req = "R4"; cfg_base = 0; cfg_mask = 28; cmp_value = 32'hF000_0007; load(0, 1);
    e0 = ev_count; h0 = hi_count; step(32);
    chk("R4", ev_count - e0, 2);
    chk("R5", hi_count - h0, 2);

    // R6: toggle, set, clear
    cur_req = "R6"; cfg_action = 1; load(0, 1);
    step(14); @(negedge clk); chk("R6", 32'(ch_out), 1);
    step(18); @(negedge clk); chk("R6", 32'(ch_out), 0);
    cfg_action = 3; load(0, 1); step(14); @(negedge clk); chk("R6", 32'(ch_out), 1);
    cfg_action = 2; load(0, 1); step(14); @(negedge clk); chk("R6", 32'(ch_out), 0);

    // R7/R12: default capture setup, rising edge on line 0
    cur_req = "R7"; cfg_mode = 1; cfg_action = 0; cfg_edge = 0; cfg_trig_sel = 0; cfg_mask = 0;
    load(32'h55, 0); step(2);
    e0 = ev_count; trig_in[0] = 1; step(6);
    chk("R7", cap_value, 32'h55);
    chk("R12", ev_count - e0, 1);
    cnt_step = 1; trig_in[0] = 0; step(3); trig_in[0] = 1; step(5);

    // R8: falling and both
    cur_req = "R8"; cfg_edge = 1; e0 = ev_count;
    trig_in[0] = 0; step(5); trig_in[0] = 1; step(5);
    chk("R8", ev_count - e0, 1);
    cfg_edge = 2; e0 = ev_count;
    trig_in[0] = 0; step(5); trig_in[0] = 1; step(5);
    chk("R8", ev_count - e0, 2);

    // R9: level pass-through
    cur_req = "R9"; trig_in[0] = 0; step(5);
    cfg_edge = 3; e0 = ev_count;
    trig_in[0] = 1; step(4); trig_in[0] = 0; step(6);
    chk("R9", ev_count - e0, 4);

    // R10: unselected line ignored
    cur_req = "R10"; cfg_edge = 0; cfg_trig_sel = 2; step(4);
    e0 = ev_count;
    for (int k = 0; k < 3; k++) begin trig_in[0] = 1; step(3); trig_in[0] = 0; step(3); end
    chk("R10", ev_count - e0, 0);
    trig_in[2] = 1; step(5); trig_in[2] = 0; step(3);
    chk("R10", ev_count - e0, 1);

    // R11: off mode stays silent
    cur_req = "R11"; cfg_mode = 0; cfg_trig_sel = 0; cmp_value = 200; load(195, 1);
    e0 = ev_count; h0 = 32'(cap_value);
    trig_in[0] = 1; step(4); trig_in[0] = 0; step(10);
    chk("R11", ev_count - e0, 0);
    chk("R11", cap_value, 32'(h0));

    step(2);
    finish_run();
  end
endmodule